// File: doc/BRIEF.md
# Register-Programmed MDIO Master with Bus Select

This block is a management-interface master that runs clause 22 and clause 45 read and write transactions on one of several MDC/MDIO buses. Software programs it through a small word-addressed register window. The buses are split into an internal group and an external group. The transaction's PHY address, write data, clause-45 flag, group flag and bus index are packed into one parameter word. The target register (and, for clause 45, the device address) goes into a separate address register. A write to the control register starts a read or a write. The status register reports completion, and a read returns its 16 captured bits in the read-data register.

The intended driver sequence has four steps. First, write 0 to the control register and see that the done flag reads 0. Second, program the parameter word and the address register. Third, write the operation code. Fourth, poll until done reads 1. One scan-control bit locks out an external management master. The block reports that lock as a grant output that an outside arbiter consumes.

MDC is divided down from the system clock. MDIO is launched after the falling edge of MDC and sampled on the rising edge. Only the selected bus toggles. Every other bus keeps MDC low and MDIO released. The block has no streaming data path: the register port, the override pins and the serial pins are all plain, level-style signals with no valid/ready handshake and no back-pressure.

Top module: `mgmt_mux_master`

## Requirements
- R1: After reset every register reads 0. Registers are at byte offsets scan-control 0x008, parameter 0x23C, read-data 0x240, address 0x244, control 0x248 and status 0x24C. The scan-control, parameter and address registers read back the full 32-bit value last written.
- R2: Writing 1 to the control register starts a write and writing 2 starts a read, but only while no transaction is running. A write of 1 or 2 during a running transaction is ignored, and the running frame continues unchanged.
- R3: Writing any other value to the control register stops the engine at once: busy and done both read 0, and MDC returns low. Status bit 0 is done and bit 1 is busy.
- R4: A clause 22 transaction is one 64-bit frame, sent MSB first. The fields are 32 ones, start 01, opcode 10 (read) or 01 (write), the PHY address from parameter bits 20:16, the register address from address-register bits 4:0, turnaround 10, and 16 data bits (write data from parameter bits 15:0).
- R5: When parameter bit 21 is set, the transaction is two frames, each with start 00. The first is an address frame with opcode 00, the device address from address-register bits 20:16 and data equal to address-register bits 15:0. The second uses opcode 01 for a write or 11 for a read.
- R6: In a read frame, the output enable is low for the two turnaround bits and the 16 data bits. The data bits are sampled on rising MDC, MSB first. The read-data register then returns them in bits 15:0, with bits 31:16 at 0.
- R7: MDC has a period of 2*CLK_DIV clocks while a transaction runs. MDC is low and every output enable is low while no transaction runs.
- R8: Parameter bit 25 set selects internal bus index bits 24:22. Bit 25 clear selects external bus NUM_INT plus that index. An index outside the group drives no bus, and a read then returns 0xFFFF.
- R9: At most one bus has MDC or output enable active, and every unselected bus holds MDC low and its output enable low.
- R10: The external grant equals the external request while scan-control bit 28 is 0, and is held low while that bit is 1.
- R11: When the last frame ends, done reads 1 and busy reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ext_req | input | 1 | External management master asks for the buses |
| ext_grant | output | 1 | External master may drive the buses |
| mdc | output | NUM_INT+NUM_EXT | Management clock per bus |
| mdio_o | output | NUM_INT+NUM_EXT | Management data out per bus |
| mdio_oe | output | NUM_INT+NUM_EXT | Management data output enable per bus |
| mdio_i | input | NUM_INT+NUM_EXT | Management data in per bus |

## Verification
The bench builds the block with CLK_DIV=2, NUM_INT=2 and NUM_EXT=2. With these values a full clause 45 transaction lasts only about 512 clocks, so every opcode, both bus groups and mid-frame control writes fit in a short run. Because the bus-index field is three bits wide, indices 2 to 7 point past each two-bus group, which makes the no-bus read-of-ones case reachable. Bits are captured per MDC edge against a behavioural frame model, and the idle buses are compared every clock.

// File: rtl/mmm_pkg.sv
package mmm_pkg;
  localparam int REG_AW     = 10;
  localparam int FRAME_BITS = 64;

  localparam logic [REG_AW-1:0] OFS_SCAN  = 10'h008;
  localparam logic [REG_AW-1:0] OFS_PARAM = 10'h23C;
  localparam logic [REG_AW-1:0] OFS_RDATA = 10'h240;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 10'h244;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 10'h248;
  localparam logic [REG_AW-1:0] OFS_STAT  = 10'h24C;

  localparam int SCAN_OVR_BIT = 28;
  localparam int PRM_INT_BIT  = 25;
  localparam int PRM_C45_BIT  = 21;

  localparam logic [31:0] CTRL_WRITE = 32'd1;
  localparam logic [31:0] CTRL_READ  = 32'd2;

  typedef struct packed {
    logic        rd;
    logic        c45;
    logic [4:0]  phy;
    logic [4:0]  dev;
    logic [15:0] regnum;
    logic [15:0] wdata;
    logic        bus_int;
    logic [2:0]  bus_idx;
  } txn_t;

  function automatic logic [FRAME_BITS-1:0] mk_frame(
    input logic [1:0]  st,
    input logic [1:0]  op,
    input logic [4:0]  phy,
    input logic [4:0]  ra,
    input logic [15:0] data
  );
    return {32'hFFFF_FFFF, st, op, phy, ra, 2'b10, data};
  endfunction
endpackage

// File: rtl/mmm_regs.sv
module mmm_regs
  import mmm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [15:0]       eng_rdata,
  output logic [31:0]       rdata,
  output logic              start,
  output logic              stop,
  output txn_t              txn,
  output logic              override
);
  logic [31:0] scan_q, param_q, addr_q, ctrl_q;
  logic        ctrl_wr, is_op;

  assign ctrl_wr = wr_en && (addr == OFS_CTRL);
  assign is_op   = (wdata == CTRL_WRITE) || (wdata == CTRL_READ);
  assign start   = ctrl_wr && is_op;
  assign stop    = ctrl_wr && !is_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q  <= '0;
      param_q <= '0;
      addr_q  <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_SCAN:  scan_q  <= wdata;
        OFS_PARAM: param_q <= wdata;
        OFS_ADDR:  addr_q  <= wdata;
        OFS_CTRL:  ctrl_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    txn.rd      = (wdata == CTRL_READ);
    txn.c45     = param_q[PRM_C45_BIT];
    txn.phy     = param_q[20:16];
    txn.dev     = addr_q[20:16];
    txn.regnum  = addr_q[15:0];
    txn.wdata   = param_q[15:0];
    txn.bus_int = param_q[PRM_INT_BIT];
    txn.bus_idx = param_q[24:22];
  end

  assign override = scan_q[SCAN_OVR_BIT];

  always_comb begin
    case (addr)
      OFS_SCAN:  rdata = scan_q;
      OFS_PARAM: rdata = param_q;
      OFS_RDATA: rdata = {16'h0000, eng_rdata};
      OFS_ADDR:  rdata = addr_q;
      OFS_CTRL:  rdata = ctrl_q;
      OFS_STAT:  rdata = {30'd0, eng_busy, eng_done};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/mmm_engine.sv
module mmm_engine
  import mmm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        stop,
  input  txn_t        txn,
  input  logic        mdi,
  output logic        run,
  output logic        done,
  output logic        mdc,
  output logic        mdo,
  output logic        mdoe,
  output logic [15:0] rdata,
  output logic        bus_int,
  output logic [2:0]  bus_idx
);
  localparam int DIV_W  = $clog2(CLK_DIV + 1);
  localparam int IDX_W  = $clog2(FRAME_BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(FRAME_BITS - 18);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(FRAME_BITS - 16);

  logic [DIV_W-1:0]      div_q;
  logic [IDX_W-1:0]      bit_q;
  logic [FRAME_BITS-1:0] frame_q, frame2_q;
  logic                  mdc_q, two_q, rd_frame_q, is_rd_q;
  logic [FRAME_BITS-1:0] f22, f45a, f45b;

  always_comb begin
    f22  = mk_frame(2'b01, txn.rd ? 2'b10 : 2'b01, txn.phy, txn.regnum[4:0],
                    txn.rd ? 16'h0000 : txn.wdata);
    f45a = mk_frame(2'b00, 2'b00, txn.phy, txn.dev, txn.regnum);
    f45b = mk_frame(2'b00, txn.rd ? 2'b11 : 2'b01, txn.phy, txn.dev,
                    txn.rd ? 16'h0000 : txn.wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; mdc_q <= 1'b0; div_q <= '0; bit_q <= '0;
      frame_q <= '0; frame2_q <= '0; two_q <= 1'b0; rd_frame_q <= 1'b0;
      is_rd_q <= 1'b0; rdata <= '0; bus_int <= 1'b0; bus_idx <= '0;
    end else if (stop) begin
      run <= 1'b0; done <= 1'b0; mdc_q <= 1'b0; div_q <= '0;
    end else if (start && !run) begin
      run     <= 1'b1;
      done    <= 1'b0;
      mdc_q   <= 1'b0;
      div_q   <= '0;
      bit_q   <= '0;
      is_rd_q <= txn.rd;
      bus_int <= txn.bus_int;
      bus_idx <= txn.bus_idx;
      if (txn.c45) begin
        frame_q    <= f45a;
        frame2_q   <= f45b;
        two_q      <= 1'b1;
        rd_frame_q <= 1'b0;
      end else begin
        frame_q    <= f22;
        frame2_q   <= '0;
        two_q      <= 1'b0;
        rd_frame_q <= txn.rd;
      end
    end else if (run) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        mdc_q <= ~mdc_q;
        if (!mdc_q) begin
          if (rd_frame_q && bit_q >= IDX_DATA) rdata <= {rdata[14:0], mdi};
        end else if (bit_q == IDX_LAST) begin
          bit_q <= '0;
          if (two_q) begin
            frame_q    <= frame2_q;
            two_q      <= 1'b0;
            rd_frame_q <= is_rd_q;
          end else begin
            run  <= 1'b0;
            done <= 1'b1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mdc  = mdc_q;
  assign mdo  = frame_q[~bit_q];
  assign mdoe = run && !(rd_frame_q && bit_q >= IDX_TA);
endmodule

// File: rtl/mmm_busmux.sv
module mmm_busmux #(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 4
) (
  input  logic                       run,
  input  logic                       bus_int,
  input  logic [2:0]                 bus_idx,
  input  logic                       mdc_c,
  input  logic                       mdo_c,
  input  logic                       mdoe_c,
  input  logic [NUM_INT+NUM_EXT-1:0] mdio_i,
  output logic [NUM_INT+NUM_EXT-1:0] mdc,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
  output logic                       mdi_c
);
  localparam int NB = NUM_INT + NUM_EXT;
  logic [NB-1:0] sel;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_int
    assign sel[i] = run && bus_int && (bus_idx == 3'(i));
  end
  for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
    assign sel[NUM_INT+j] = run && !bus_int && (bus_idx == 3'(j));
  end
  for (genvar k = 0; k < NB; k++) begin : g_pin
    assign mdc[k]     = sel[k] & mdc_c;
    assign mdio_o[k]  = sel[k] & mdo_c;
    assign mdio_oe[k] = sel[k] & mdoe_c;
  end

  assign mdi_c = (|(sel & mdio_i)) | ~(|sel);
endmodule

// File: rtl/mgmt_mux_master.sv
module mgmt_mux_master
  import mmm_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic                       ext_req,
  output logic                       ext_grant,
  output logic [NUM_INT+NUM_EXT-1:0] mdc,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
  input  logic [NUM_INT+NUM_EXT-1:0] mdio_i
);
  localparam int NB = NUM_INT + NUM_EXT;

  txn_t        txn;
  logic        start, stop, scan_ovr;
  logic        eng_run, eng_done, eng_mdc, eng_mdo, eng_mdoe, eng_mdi;
  logic [15:0] eng_rdata;
  logic        sel_int;
  logic [2:0]  sel_idx;

  mmm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .eng_busy(eng_run), .eng_done(eng_done),
    .eng_rdata(eng_rdata), .rdata(reg_rdata), .start(start), .stop(stop),
    .txn(txn), .override(scan_ovr)
  );

  mmm_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .txn(txn),
    .mdi(eng_mdi), .run(eng_run), .done(eng_done), .mdc(eng_mdc),
    .mdo(eng_mdo), .mdoe(eng_mdoe), .rdata(eng_rdata),
    .bus_int(sel_int), .bus_idx(sel_idx)
  );

  mmm_busmux #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) u_mux (
    .run(eng_run), .bus_int(sel_int), .bus_idx(sel_idx), .mdc_c(eng_mdc),
    .mdo_c(eng_mdo), .mdoe_c(eng_mdoe), .mdio_i(mdio_i), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdi_c(eng_mdi)
  );

  assign ext_grant = ext_req & ~scan_ovr;
endmodule

// File: rtl/mmm_checker.sv
module mmm_checker
  import mmm_pkg::*;
#(
  parameter int NB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              busy,
  input logic              done,
  input logic [NB-1:0]     mdc,
  input logic [NB-1:0]     mdio_oe,
  input logic              ext_grant
);
  p_one_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc) && $onehot0(mdio_oe));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc == '0) && (mdio_oe == '0));

  p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_CTRL && reg_wdata == 32'd0) |=> (!done && !busy));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_CTRL && (reg_wdata == CTRL_READ || reg_wdata == CTRL_WRITE) && !busy)
      |=> busy);

  p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == OFS_SCAN && reg_wdata[SCAN_OVR_BIT]) |=> !ext_grant);

  p_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

bind mgmt_mux_master mmm_checker #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(eng_run), .done(eng_done), .mdc(mdc),
  .mdio_oe(mdio_oe), .ext_grant(ext_grant)
);

// File: tb/sim_mgmt_mux_master.sv
`timescale 1ns/1ps
module sim_mgmt_mux_master;
  localparam int DIV = 2, NI = 2, NE = 2, NB = NI + NE;
  localparam logic [9:0] A_SCAN = 10'h008, A_PRM = 10'h23C, A_RD = 10'h240,
                         A_ADR = 10'h244, A_CTL = 10'h248, A_ST = 10'h24C;

  logic clk = 0, rst_n = 0, reg_wr_en = 0, ext_req = 0, ext_grant;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NB-1:0] mdc, mdio_o, mdio_oe, mdio_i;

  always #5 clk = ~clk;

  mgmt_mux_master #(.CLK_DIV(DIV), .NUM_INT(NI), .NUM_EXT(NE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
    .ext_grant(ext_grant), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int vecs = 0, fails = 0, mon_vecs = 0, mon_fails = 0;
  int mon_bus = -1, cap_base = 0, cap_n = 0;
  logic [15:0] pat = '0;
  bit cap_oe [0:2047];
  bit cap_d  [0:2047];
  bit finished = 0;

  // monitor: idle buses every clock, selected bus bits on each MDC rise
  int cyc = 0, last_rise = 0;
  bit prev_mdc = 0;
  initial mdio_i = '1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      for (int i = 0; i < NB; i++) begin
        if (i != mon_bus) begin
          mon_vecs++;
          if (mdc[i] || mdio_oe[i]) begin
            mon_fails++;
            $display("FAIL R9 bus %0d idle: mdc=%0b oe=%0b expected 0 0", i, mdc[i], mdio_oe[i]);
          end
        end
      end
    end
    if (mon_bus >= 0) begin
      if (mdc[mon_bus] && !prev_mdc) begin
        cap_oe[cap_n % 2048] = mdio_oe[mon_bus];
        cap_d[cap_n % 2048]  = mdio_o[mon_bus];
        if (cap_n > cap_base) begin
          mon_vecs++;
          if (cyc - last_rise != 2*DIV) begin
            mon_fails++;
            $display("FAIL R7 MDC period: actual %0d expected %0d", cyc - last_rise, 2*DIV);
          end
        end
        last_rise = cyc;
        cap_n++;
      end
      prev_mdc = mdc[mon_bus];
      mdio_i = '1;
      if ((cap_n - cap_base) % 64 >= 48)
        mdio_i[mon_bus] = pat[63 - ((cap_n - cap_base) % 64)];
    end else begin
      prev_mdc = 0;
      mdio_i = '1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] prm(input logic [15:0] d, input logic [4:0] phy,
                                      input bit c45, input logic [2:0] idx, input bit inb);
    return {6'd0, inb, idx, c45, phy, d};
  endfunction

  function automatic logic [63:0] frm(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFFFFFF, st, op, phy, ra, 2'b10, d};
  endfunction

  task automatic run_txn(input logic [31:0] p, input logic [31:0] adr, input int op,
                         input int bus, input logic [15:0] ppat, input bit poke, input string tag);
    logic [31:0] s;
    logic [63:0] f0, f1, fr;
    bit c45, rdop, eoe, rel;
    int nb, mism, k;
    mon_bus = bus; pat = ppat;
    wr(A_CTL, 0);
    rd(A_ST, s); chk(s == 0, {tag, " R3 status after clear"}, s, 0);
    cap_base = cap_n;
    wr(A_PRM, p); wr(A_ADR, adr); wr(A_CTL, op);
    if (poke) begin
      repeat (20) @(negedge clk);
      wr(A_CTL, 2);
    end
    for (int t = 0; t < 2000; t++) begin
      rd(A_ST, s);
      if (s[0]) break;
    end
    chk(s == 1, {tag, " R11 done/busy"}, s, 1);
    c45 = p[21]; rdop = (op == 2);
    nb = (bus < 0) ? 0 : (c45 ? 128 : 64);
    chk(cap_n - cap_base == nb, {tag, " R4 R5 bit count"}, cap_n - cap_base, nb);
    if (c45) begin
      f0 = frm(2'b00, 2'b00, p[20:16], adr[20:16], adr[15:0]);
      f1 = frm(2'b00, rdop ? 2'b11 : 2'b01, p[20:16], adr[20:16], p[15:0]);
    end else begin
      f0 = frm(2'b01, rdop ? 2'b10 : 2'b01, p[20:16], adr[4:0], p[15:0]);
      f1 = '0;
    end
    mism = 0;
    if (cap_n - cap_base == nb) begin
      for (int j = 0; j < nb; j++) begin
        fr = (j < 64) ? f0 : f1;
        k = j % 64;
        rel = rdop && (!c45 || j >= 64) && k >= 46;
        eoe = !rel;
        if (cap_oe[(cap_base + j) % 2048] != eoe) mism++;
        else if (eoe && cap_d[(cap_base + j) % 2048] != fr[63 - k]) mism++;
      end
    end
    if (nb > 0) chk(mism == 0, {tag, " R4 R5 R6 frame bits/oe mismatches"}, mism, 0);
    if (rdop) begin
      rd(A_RD, s);
      chk(s == {16'h0, (bus < 0) ? 16'hFFFF : ppat}, {tag, " R6 R8 read data"}, s,
          {16'h0, (bus < 0) ? 16'hFFFF : ppat});
    end
    mon_bus = -1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs + mon_vecs, fails + mon_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(A_ST, s);   chk(s == 0, "R1 status reset", s, 0);
    rd(A_PRM, s);  chk(s == 0, "R1 param reset", s, 0);
    rd(A_SCAN, s); chk(s == 0, "R1 scan reset", s, 0);
    chk(mdc == 0 && mdio_oe == 0, "R7 idle pins after reset", {mdc, mdio_oe}, 0);
    // R1 readback
    wr(A_PRM, 32'hA5C3_1234); rd(A_PRM, s); chk(s == 32'hA5C3_1234, "R1 param readback", s, 32'hA5C3_1234);
    wr(A_ADR, 32'h0012_ABCD); rd(A_ADR, s); chk(s == 32'h0012_ABCD, "R1 addr readback", s, 32'h0012_ABCD);
    // R10 override
    ext_req = 1;
    @(negedge clk); chk(ext_grant == 1, "R10 grant while unlocked", ext_grant, 1);
    wr(A_SCAN, 32'h1000_0000); rd(A_SCAN, s); chk(s == 32'h1000_0000, "R1 scan readback", s, 32'h1000_0000);
    chk(ext_grant == 0, "R10 grant while locked", ext_grant, 0);
    // R4 R8 clause 22 write internal bus 1
    run_txn(prm(16'hBEEF, 5'd5, 0, 3'd1, 1), 32'h0000_000A, 1, 1, 16'h0, 0, "c22 wr int1");
    // R6 R8 clause 22 read external bus 1 (pin 3)
    run_txn(prm(16'h0, 5'd17, 0, 3'd1, 0), 32'h0000_0013, 2, NI + 1, 16'hA5C3, 0, "c22 rd ext1");
    // R5 clause 45 write internal bus 0
    run_txn(prm(16'h5555, 5'd3, 1, 3'd0, 1), 32'h0007_1234, 1, 0, 16'h0, 0, "c45 wr int0");
    // R5 R6 clause 45 read external bus 0 (pin 2)
    run_txn(prm(16'h0, 5'd9, 1, 3'd0, 0), 32'h001E_8001, 2, NI, 16'h0F0F, 0, "c45 rd ext0");
    // R8 index out of range: no bus, read of ones
    run_txn(prm(16'h0, 5'd1, 0, 3'd3, 1), 32'h0000_0001, 2, -1, 16'h1234, 0, "no bus");
    // R2 start while busy is ignored
    run_txn(prm(16'h3C96, 5'd30, 0, 3'd0, 0), 32'h0000_001F, 1, NI, 16'h0, 1, "R2 busy poke");
    // R3 abort mid-frame
    mon_bus = 1; cap_base = cap_n;
    wr(A_PRM, prm(16'h0, 5'd2, 0, 3'd1, 1)); wr(A_ADR, 32'h2); wr(A_CTL, 2);
    repeat (30) @(negedge clk);
    rd(A_ST, s); chk(s == 2, "R3 busy bit mid-frame", s, 2);
    wr(A_CTL, 32'd7);
    mon_bus = -1;
    rd(A_ST, s); chk(s == 0, "R3 status after abort", s, 0);
    chk(mdc == 0 && mdio_oe == 0, "R3 pins after abort", {mdc, mdio_oe}, 0);
    repeat (10) @(negedge clk);
    summary();
  end
endmodule